// File: doc/BRIEF.md
# Bus-Activity Watchdog Supervisor

This block supervises a host processor through the traffic it puts on a serial control bus. Each time the bus interface finishes a transaction it raises a one-cycle strobe. The watchdog counts how long the bus has been quiet. If the quiet time reaches the timeout, the block issues a recovery request: either a soft reset of the system or a full power cycle. Two enable bits choose which request is issued.

The quiet time is measured with a prescaler that produces a slow tick, plus a tick counter. Both are parameters. The defaults give a 4 s timeout from a 32768 Hz clock: 32 clocks per tick and 4096 ticks. A bench can set small values instead.

When both enable bits are low, the counter is held at zero. Any bus transaction restarts the quiet period. After each expiry the count starts again, so a second request needs a second full silent period.

Top module: `bus_watchdog`

## Requirements
- R1: After synchronous reset, both request outputs are 0.
- R2: While `soft_rst_en` and `pwr_cycle_en` are both 0, no request is ever issued. A bus strobe in this state has no effect.
- R3: A request is issued after exactly TICK_DIV*TIMEOUT_TICKS consecutive clock edges that are armed and have no strobe. It is visible in the cycle after the last of those edges, and it never appears one edge earlier.
- R4: A `txn_done` strobe at an armed clock edge restarts the quiet count from zero, and no request follows that edge.
- R5: On expiry with only `soft_rst_en` set, `soft_rst_req` pulses and `pwr_cycle_req` stays 0.
- R6: On expiry with only `pwr_cycle_en` set, `pwr_cycle_req` pulses and `soft_rst_req` stays 0.
- R7: On expiry with both enables set, only `pwr_cycle_req` pulses. The two requests are never high together.
- R8: Each request is high for exactly one cycle. If the bus stays silent after a request, the next request comes one full timeout period later.
- R9: An edge at which both enables are 0 discards the quiet time counted so far. After re-arming, a full period is needed again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txn_done | input | 1 | One-cycle strobe for each completed bus transaction |
| soft_rst_en | input | 1 | Arms the watchdog and selects a soft-reset request on expiry |
| pwr_cycle_en | input | 1 | Arms the watchdog and selects a power-cycle request on expiry; takes priority |
| soft_rst_req | output | 1 | Registered one-cycle soft-reset request |
| pwr_cycle_req | output | 1 | Registered one-cycle power-cycle request |

## Verification
The bench checks the exact expiry edge against a single-counter reference model. A design that let its prescaler run on across a bus strobe would fire a few cycles early. A design that kept the tick count through a disarmed cycle would fire early after re-arming. The bench sets both enables together, and a design without the priority rule would raise both requests or the wrong one. The bench also lets the bus stay silent after a request. A design that did not restart its counter would then give a multi-cycle pulse, or a second request before a full period has passed.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_SOFT  = 2'd1,
    ACT_CYCLE = 2'd2
  } wdg_action_e;

  // Power cycle outranks soft reset when both are enabled.
  function automatic wdg_action_e choose_action(input logic soft_en,
                                                input logic cyc_en);
    if (cyc_en)       return ACT_CYCLE;
    else if (soft_en) return ACT_SOFT;
    else              return ACT_NONE;
  endfunction

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_passthru
      assign tick = ~clear;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] cnt;
      logic         at_last;

      assign at_last = (cnt == LAST);
      assign tick    = ~clear & at_last;

      always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (at_last) cnt <= '0;
        else              cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdg_timeout_cnt.sv
module wdg_timeout_cnt #(
  parameter int TICKS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic expire
);
  generate
    if (TICKS <= 1) begin : g_single
      assign expire = tick;
    end else begin : g_count
      localparam int W = $clog2(TICKS);
      localparam logic [W-1:0] LAST = W'(TICKS - 1);
      logic [W-1:0] cnt;

      assign expire = tick & (cnt == LAST);

      always_ff @(posedge clk) begin
        if (rst || clear || expire) cnt <= '0;
        else if (tick)              cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/wdg_action_sel.sv
module wdg_action_sel
  import wdg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic soft_en,
  input  logic cyc_en,
  output logic soft_req,
  output logic cyc_req
);
  wdg_action_e act;

  assign act = expire ? choose_action(soft_en, cyc_en) : ACT_NONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_req <= 1'b0;
      cyc_req  <= 1'b0;
    end else begin
      soft_req <= (act == ACT_SOFT);
      cyc_req  <= (act == ACT_CYCLE);
    end
  end
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog #(
  parameter int TICK_DIV      = 32,
  parameter int TIMEOUT_TICKS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic txn_done,
  input  logic soft_rst_en,
  input  logic pwr_cycle_en,
  output logic soft_rst_req,
  output logic pwr_cycle_req
);
  logic armed;
  logic restart;
  logic tick;
  logic expire;

  assign armed   = soft_rst_en | pwr_cycle_en;
  assign restart = ~armed | txn_done;

  wdg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (restart),
    .tick  (tick)
  );

  wdg_timeout_cnt #(.TICKS(TIMEOUT_TICKS)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clear  (restart),
    .tick   (tick),
    .expire (expire)
  );

  wdg_action_sel u_act (
    .clk      (clk),
    .rst      (rst),
    .expire   (expire),
    .soft_en  (soft_rst_en),
    .cyc_en   (pwr_cycle_en),
    .soft_req (soft_rst_req),
    .cyc_req  (pwr_cycle_req)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int TICK_DIV      = 32,
  parameter int TIMEOUT_TICKS = 4096
) (
  input logic clk,
  input logic rst,
  input logic txn_done,
  input logic soft_rst_en,
  input logic pwr_cycle_en,
  input logic soft_rst_req,
  input logic pwr_cycle_req
);
  localparam int LIMIT = TICK_DIV * TIMEOUT_TICKS;
  localparam int QW    = $clog2(LIMIT + 1);
  localparam logic [QW-1:0] QLIM = QW'(LIMIT);

  logic [QW-1:0] quiet;
  logic          armed;

  assign armed = soft_rst_en | pwr_cycle_en;

  always_ff @(posedge clk) begin
    if (rst || !armed || txn_done) quiet <= '0;
    else if (quiet == QLIM)        quiet <= QW'(1);
    else                           quiet <= quiet + 1'b1;
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(soft_rst_req && pwr_cycle_req)); // R7
  AST_DISARMED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst_en && !pwr_cycle_en) |=> (!soft_rst_req && !pwr_cycle_req)); // R2
  AST_TXN_RESTART: assert property (@(posedge clk) disable iff (rst)
    (txn_done && armed) |=> (!soft_rst_req && !pwr_cycle_req)); // R4
  AST_SOFT_SELECT: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |-> $past(soft_rst_en && !pwr_cycle_en)); // R5
  AST_CYCLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    pwr_cycle_req |-> $past(pwr_cycle_en)); // R6
  AST_SOFT_PULSE: assert property (@(posedge clk) disable iff (rst)
    soft_rst_req |=> !soft_rst_req); // R8
  AST_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pwr_cycle_req |=> !pwr_cycle_req); // R8
  AST_EXACT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (soft_rst_req || pwr_cycle_req) |-> (quiet == QLIM)); // R3
endmodule

bind bus_watchdog wdg_checker #(
  .TICK_DIV      (TICK_DIV),
  .TIMEOUT_TICKS (TIMEOUT_TICKS)
) u_wdg_chk (
  .clk           (clk),
  .rst           (rst),
  .txn_done      (txn_done),
  .soft_rst_en   (soft_rst_en),
  .pwr_cycle_en  (pwr_cycle_en),
  .soft_rst_req  (soft_rst_req),
  .pwr_cycle_req (pwr_cycle_req)
);

// File: tb/tb_bus_watchdog.sv
module tb_bus_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int TTICKS     = 5;
  localparam int LIMIT      = TDIV * TTICKS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txn = 1'b0;
  logic sr  = 1'b0;
  logic pc  = 1'b0;
  logic sr_req, pc_req;

  int checks = 0;
  int fails  = 0;
  int silent = 0;
  logic [1:0] expv = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_watchdog #(.TICK_DIV(TDIV), .TIMEOUT_TICKS(TTICKS)) dut (
    .clk           (clk),
    .rst           (rst),
    .txn_done      (txn),
    .soft_rst_en   (sr),
    .pwr_cycle_en  (pc),
    .soft_rst_req  (sr_req),
    .pwr_cycle_req (pc_req)
  );

  // Returns {power-cycle, soft-reset} for an expiry under the given enables.
  function automatic logic [1:0] pick_req(input logic s, input logic p);
    return {p, s & ~p};
  endfunction

  task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {pc_req,sr_req} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic s, input logic p, input string tag);
    @(negedge clk);
    txn = t; sr = s; pc = p;
    @(posedge clk);
    expv = 2'b00;
    if (!(s | p) || t) silent = 0;
    else begin
      silent++;
      if (silent == LIMIT) begin
        expv   = pick_req(s, p);
        silent = 0;
      end
    end
    #1;
    check({pc_req, sr_req}, expv, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    silent = 0;
    check({pc_req, sr_req}, 2'b00, "R1 reset");

    // R2: disarmed, strobes ignored over more than a full period
    for (int i = 0; i < 3 * LIMIT; i++) step(i % 3 == 0, 1'b0, 1'b0, "R2 disarmed");

    // R3/R5: soft only, exact edge; R8: repeat after another period
    for (int i = 0; i < LIMIT; i++) step(1'b0, 1'b1, 1'b0, "R3 R5 soft expiry");
    for (int i = 0; i < LIMIT + 2; i++) step(1'b0, 1'b1, 1'b0, "R8 pulse repeat");

    // R4: strobe partway restarts the count
    step(1'b1, 1'b1, 1'b0, "R4 restart");
    for (int i = 0; i < LIMIT - 3; i++) step(1'b0, 1'b1, 1'b0, "R4 restart");
    step(1'b1, 1'b1, 1'b0, "R4 restart");
    for (int i = 0; i < LIMIT + 1; i++) step(1'b0, 1'b1, 1'b0, "R4 after restart");

    // R6: power cycle only
    step(1'b1, 1'b0, 1'b1, "R6 cycle");
    for (int i = 0; i < LIMIT + 1; i++) step(1'b0, 1'b0, 1'b1, "R6 cycle expiry");

    // R7: both enabled
    step(1'b1, 1'b1, 1'b1, "R7 priority");
    for (int i = 0; i < LIMIT + 1; i++) step(1'b0, 1'b1, 1'b1, "R7 priority expiry");

    // R9: disarm for one edge discards quiet time
    step(1'b1, 1'b1, 1'b0, "R9 disarm");
    for (int i = 0; i < LIMIT - 2; i++) step(1'b0, 1'b1, 1'b0, "R9 disarm");
    step(1'b0, 1'b0, 1'b0, "R9 disarm");
    for (int i = 0; i < LIMIT + 1; i++) step(1'b0, 1'b1, 1'b0, "R9 rearm full period");

    // Random traffic and enable changes
    begin
      logic s_r, p_r;
      s_r = 1'b1; p_r = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 99) == 0) begin
          s_r = 1'($urandom_range(0, 1));
          p_r = 1'($urandom_range(0, 1));
        end
        step($urandom_range(0, 39) == 0, s_r, p_r, "R3 R4 R7 random");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule